// File: doc/BRIEF.md
# Two-Channel Programmable Card Clock Divider

This block derives a smart card clock from the chip's master clock in two stages. The first stage is a programmable prescaler. It counts master clock cycles and gives a terminal-count pulse once every (divisor + 1) cycles. That pulse is the elementary-time-unit rate enable for a downstream ETU counter. The second stage is a toggle flop driven by the same terminal count. It gives a card clock with a 50% duty cycle and a period of 2×(divisor + 1) master cycles. The card clock is a registered signal in the master clock domain, so nothing is gated.

The block has two identical channels. Channel 0 serves the internal card interface and channel 1 serves the external one. Each channel holds its own 6-bit divisor. Software writes a divisor through an 8-bit write port and can read it back. A written value first goes to a holding register. The counter picks it up only at its next terminal count, so each card clock phase runs a whole number of cycles under a single ratio. A divisor of zero acts exactly like a divisor of one.

Top module: `sccd_clkgen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, both channels read back 0x0C and hold `card_clk` and `etu_tick` low. After `rst_n` rises, the first `etu_tick` on each channel appears 13 master cycles later.
- R2: With a divisor d in 1..63 in effect, every high phase and every low phase of `card_clk` lasts exactly d+1 master cycles, so the period is 2×(d+1).
- R3: A divisor of 0 gives the same timing as a divisor of 1: phases of 2 cycles and a period of 4.
- R4: `etu_tick` is high for exactly one cycle per terminal count, and it is high in exactly those cycles in which `card_clk` has just changed level.
- R5: A write is a cycle with `wr_en` high. `wr_sel` = 0 selects the internal channel and 1 selects the external channel. `wr_data[5:0]` is stored. From the next cycle the channel's 8-bit readback field (bits 7:0 of `div_rd` for channel 0, bits 15:8 for channel 1) holds the stored value in bits 5:0 and zero in bits 7:6, whatever was written to bits 7:6.
- R6: A new divisor does not change the phase in progress when it is written. It governs timing only from the next toggle of `card_clk`. Every phase is d_old+1 or d_new+1 cycles long, never shorter than the smaller of the two. From the second full phase after the write, every phase is d_new+1 cycles.
- R7: A write to one channel leaves the other channel's readback and card clock timing unchanged.
- R8: Pulling `rst_n` low in mid-run, for at least one clock edge, discards any written divisors. Both channels return to divisor 0x0C with the counter and card clock cleared, and restart as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Divisor write strobe |
| wr_sel | input | 1 | Channel select for a write: 0 internal, 1 external |
| wr_data | input | 8 | Write data; bits 5:0 are the divisor |
| div_rd | output | 16 | Readback: channel 0 in 7:0, channel 1 in 15:8 |
| etu_tick | output | 2 | One-cycle terminal-count pulse per channel |
| card_clk | output | 2 | Divided card clock per channel |

## Verification
The hardest case to reach is a divisor write that lands on the very edge where the counter wraps. The new value must then wait a whole extra phase without shortening or stretching the current one. The stimulus writes new divisors after a random delay of 0 to 130 master cycles, which covers every offset within a phase, including the wrap edge. It then checks each following phase length against the old and new half-periods. An exhaustive sweep over all 64 divisor values on both channels at once covers the zero clamp and the largest ratio.

// File: rtl/sccd_pkg.sv
// Package: shared constants and helpers for the card clock divider.
// Assumes divisors are unsigned and at most 6 bits wide by default.
package sccd_pkg;
    localparam int unsigned DEF_DIV_W  = 6;
    localparam int unsigned DEF_REG_W  = 8;
    localparam int unsigned DEF_NUM_CH = 2;
    localparam int unsigned DEF_RST_DIV = 12;
endpackage

// File: rtl/sccd_div_reg.sv
// Module: holding register for one channel's divisor.
// Captures the low DIV_W bits of a write and presents them, zero-extended,
// as the readback field. Assumes wr_stb is already decoded for this channel.
module sccd_div_reg #(
    parameter int unsigned DIV_W   = 6,
    parameter int unsigned REG_W   = 8,
    parameter int unsigned RST_DIV = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [DIV_W-1:0] wr_div,
    output logic [DIV_W-1:0] hold_q,
    output logic [REG_W-1:0] rd_data
);
    localparam int unsigned PAD_W = REG_W - DIV_W;

    // Purpose: store the most recently written divisor.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= DIV_W'(RST_DIV);
        else if (wr_stb) hold_q <= wr_div;
    end

    // Purpose: readback with the unused upper bits forced to zero.
    always_comb rd_data = {{PAD_W{1'b0}}, hold_q};

    // R5
    hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> hold_q == $past(wr_div));

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(hold_q));
endmodule

// File: rtl/sccd_prescaler.sv
// Module: programmable prescaler for one channel.
// Counts 0..eff and wraps, where eff is the active divisor, with zero raised
// to one. The held divisor becomes active only on a wrap. Gives a
// combinational wrap flag and a registered one-cycle tick.
module sccd_prescaler #(
    parameter int unsigned DIV_W   = 6,
    parameter int unsigned RST_DIV = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] hold_div,
    output logic             wrap,
    output logic             tick_q
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] act_q;
    logic [DIV_W-1:0] eff;

    // Purpose: clamp a zero divisor to one.
    always_comb eff = (act_q == '0) ? DIV_W'(1) : act_q;

    // Purpose: detect the terminal count.
    always_comb wrap = (cnt_q == eff);

    // Purpose: advance the counter; load the new ratio only on a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= DIV_W'(RST_DIV);
        end else if (wrap) begin
            cnt_q <= '0;
            act_q <= hold_div;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: register the terminal count as the ETU enable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= wrap;
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= eff);

    // R6
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wrap) |-> act_q == $past(act_q));

    // R4
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);
endmodule

// File: rtl/sccd_toggle.sv
// Module: divide-by-two stage.
// Flips a registered level once per advance pulse from the prescaler.
// Assumes the advance pulses are never in back-to-back cycles.
module sccd_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic lvl_q
);
    // Purpose: toggle the card clock level on each terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)   lvl_q <= 1'b0;
        else if (adv) lvl_q <= ~lvl_q;
    end

    // R2
    lvl_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(lvl_q));
endmodule

// File: rtl/sccd_clkgen.sv
// Module: top of the two-channel card clock divider.
// Decodes divisor writes per channel and instantiates one holding register,
// one prescaler and one toggle stage for each channel. All outputs are
// registered in the master clock domain.
module sccd_clkgen #(
    parameter int unsigned NUM_CH  = sccd_pkg::DEF_NUM_CH,
    parameter int unsigned DIV_W   = sccd_pkg::DEF_DIV_W,
    parameter int unsigned REG_W   = sccd_pkg::DEF_REG_W,
    parameter int unsigned RST_DIV = sccd_pkg::DEF_RST_DIV,
    localparam int unsigned SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [REG_W-1:0]        wr_data,
    output logic [NUM_CH*REG_W-1:0] div_rd,
    output logic [NUM_CH-1:0]       etu_tick,
    output logic [NUM_CH-1:0]       card_clk
);
    logic unused_hi_bits;
    assign unused_hi_bits = ^wr_data[REG_W-1:DIV_W];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [SEL_W-1:0] CH_ID = SEL_W'(c);
        logic             stb;
        logic [DIV_W-1:0] hold;
        logic             wrap;

        // Purpose: route a write to this channel only.
        always_comb stb = wr_en && (wr_sel == CH_ID);

        sccd_div_reg #(.DIV_W(DIV_W), .REG_W(REG_W), .RST_DIV(RST_DIV)) u_reg (
            .clk(clk), .rst_n(rst_n), .wr_stb(stb), .wr_div(wr_data[DIV_W-1:0]),
            .hold_q(hold), .rd_data(div_rd[c*REG_W +: REG_W]));

        sccd_prescaler #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_pre (
            .clk(clk), .rst_n(rst_n), .hold_div(hold),
            .wrap(wrap), .tick_q(etu_tick[c]));

        sccd_toggle u_tgl (
            .clk(clk), .rst_n(rst_n), .adv(wrap), .lvl_q(card_clk[c]));

        // R4
        tick_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (card_clk[c] != $past(card_clk[c])) == etu_tick[c]);

        // R5
        wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == CH_ID) |=>
            div_rd[c*REG_W +: REG_W] == {{(REG_W-DIV_W){1'b0}}, $past(wr_data[DIV_W-1:0])});

        // R7
        other_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_sel == CH_ID) |=> $stable(div_rd[c*REG_W +: REG_W]));
    end
endmodule

// File: tb/sccd_clkgen_tb.sv
`timescale 1ns/1ps
module sccd_clkgen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_sel = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [15:0] div_rd;
    logic [1:0]  etu_tick;
    logic [1:0]  card_clk;

    int n_chk = 0;
    int n_err = 0;
    int mon_err = 0;
    bit mon_arm = 0;
    bit done = 0;
    logic [1:0] prev_lvl = 2'b00;

    always #2.5 clk = ~clk;

    sccd_clkgen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .div_rd(div_rd), .etu_tick(etu_tick), .card_clk(card_clk));

    function automatic int half(input int d);
        return (d == 0) ? 2 : d + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R4 monitor: the tick must coincide with each change of card clock level
    always @(negedge clk) begin
        if (rst_n && mon_arm)
            for (int c = 0; c < 2; c++)
                if (etu_tick[c] != (card_clk[c] != prev_lvl[c])) mon_err++;
        prev_lvl <= card_clk;
    end

    task automatic wr(input int ch, input logic [7:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_sel = ch[0]; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic get_phase(input int ch, output int len);
        logic p;
        p = card_clk[ch];
        do @(negedge clk); while (card_clk[ch] == p);
        p = card_clk[ch];
        len = 0;
        do begin @(negedge clk); len++; end while (card_clk[ch] == p);
    endtask

    task automatic do_reset(input string req);
        int n;
        @(negedge clk); #1; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(div_rd == 16'h0C0C, req, "reset readback", div_rd, 16'h0C0C);
        chk(card_clk == 2'b00 && etu_tick == 2'b00, req, "reset outputs",
            {card_clk, etu_tick}, 0);
        #1; rst_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (etu_tick[0] == 1'b0 && n < 100);
        chk(n == 13, req, "first tick delay", n, 13);
        chk(etu_tick[1] == 1'b1, req, "ch1 first tick aligned", etu_tick[1], 1);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int len, len2, cur, nw, mn;
        // R1 reset state and first tick
        do_reset("R1");
        mon_arm = 1;
        get_phase(0, len);
        chk(len == 13, "R1", "default phase", len, 13);

        // R5 upper bits ignored, stored value used
        wr(0, 8'hC5);
        chk(div_rd[7:0] == 8'h05, "R5", "readback masks 7:6", div_rd[7:0], 8'h05);
        // R7 other channel untouched
        chk(div_rd[15:8] == 8'h0C, "R7", "ch1 readback after ch0 write", div_rd[15:8], 8'h0C);
        get_phase(1, len); get_phase(1, len);
        chk(len == 13, "R7", "ch1 phase after ch0 write", len, 13);
        get_phase(0, len); get_phase(0, len);
        chk(len == 6, "R5", "ch0 phase with divisor 5", len, 6);

        // R2 R3 exhaustive sweep, channel 1 runs the reverse order
        for (int d = 0; d < 64; d++) begin
            wr(0, 8'(d));
            wr(1, 8'(63 - d));
            chk(div_rd == {8'(63 - d), 8'(d)}, "R5", "sweep readback", div_rd, {8'(63 - d), 8'(d)});
            get_phase(0, len); get_phase(0, len);
            get_phase(0, len); get_phase(0, len2);
            chk(len == half(d) && len2 == half(d), d < 2 ? "R3" : "R2",
                "ch0 phase", len, half(d));
            get_phase(1, len); get_phase(1, len); get_phase(1, len);
            chk(len == half(63 - d), (63 - d) < 2 ? "R3" : "R2", "ch1 phase", len, half(63 - d));
        end

        // R6 writes at random points in the cycle
        cur = 0;
        wr(0, 8'd0);
        get_phase(0, len); get_phase(0, len);
        for (int i = 0; i < 40; i++) begin
            nw = $urandom_range(0, 63);
            if (i == 3) nw = 0;
            if (i == 4) nw = 63;
            repeat ($urandom_range(0, 130)) @(negedge clk);
            wr(0, 8'(nw));
            mn = (half(cur) < half(nw)) ? half(cur) : half(nw);
            for (int k = 0; k < 4; k++) begin
                get_phase(0, len);
                if (k < 2)
                    chk((len == half(cur) || len == half(nw)) && len >= mn, "R6",
                        "phase after write", len, half(nw));
                else
                    chk(len == half(nw), "R6", "settled phase", len, half(nw));
            end
            cur = nw;
        end

        // R8 mid-run reset discards written divisors
        wr(0, 8'd3); wr(1, 8'd7);
        repeat (5) @(negedge clk);
        do_reset("R8");
        get_phase(1, len);
        chk(len == 13, "R8", "ch1 phase after reset", len, 13);

        chk(mon_err == 0, "R4", "tick/toggle mismatches", mon_err, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule